// File: doc/BRIEF.md
# Compare-Driven Timer with Output Modes

A free-running timer counter with one period register and a parameterised number of compare channels. Each channel drives one output pin through a 3-bit output mode. Each mode names a first action, taken when the counter reaches the channel's compare value, and an optional second action, taken on a period event. A clock enable gates every count step, so the counter advances one tick per enabled cycle. A one-cycle flag marks each return of the counter to zero.

There are four counter modes: stop, up, continuous and up/down. In up mode the counter holds the period value for a full tick before it returns to zero, so one period lasts period+1 ticks. In that mode the period event is the counter becoming zero after the wrap, not the counter matching the period value. This makes pulse-width modulation simple. A compare value k in reset/set mode gives an output that is high for k ticks of every cycle. Any k above the period gives 100 %, and zero gives 0 %. In continuous and up/down modes the period event is equality with the period register.

Top module: `tcmp_unit`

## Requirements
- R1: The reset state is count 0, every channel output 0 and the wrap flag 0. With counter mode 1 (up), each enabled tick moves the count from c to c+1 while c is below the period value. When c is at or above the period value, the count goes to 0, so one period is period+1 ticks.
- R2: With counter mode 2 (continuous), each enabled tick adds 1 to the count, and the count goes from all ones to 0.
- R3: With counter mode 0 (stop), or with tick_en low, the count holds. Outputs in modes 1 to 7 also hold.
- R4: With counter mode 3 (up/down), the count rises from 0 to the period value and falls back to 0, so one full cycle is 2×period ticks.
- R5: wrap_pulse is 1 for exactly the cycles in which an enabled, running tick has just left the count at 0.
- R6: In output mode 0, a channel output equals its out_bit input as sampled at the previous clock edge, whatever the counter is doing.
- R7: The output modes are coded as follows, with the compare action first and the period action second. 1 = set / none. 2 = toggle / clear. 3 = set / clear. 4 = toggle / none. 5 = clear / none. 6 = toggle / set. 7 = clear / set.
- R8: In up mode the period event is the count becoming 0 after a wrap. In mode 3 with period 0x18 and compare 0x17, the output is high 2 of every 25 ticks. With compare equal to the period, it is high 1 tick of every period.
- R9: In continuous and up/down modes, the period event is the count becoming equal to the period value.
- R10: When the compare event and the period event fall on the same tick, the compare action wins. In up mode with compare 0 in mode 7, the output stays low. With compare 1 in mode 7, it is high 1 tick at the start of each period.
- R11: In up mode with period 99 and output mode 7, compare 100 gives 100 high ticks of every 100, and compare 50 gives 50.
- R12: Output changes are registered. They show on the same clock edge at which the count takes the triggering value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable, one tick per enabled cycle |
| cnt_mode | input | 2 | Counter mode: 0 stop, 1 up, 2 continuous, 3 up/down |
| period_val | input | WIDTH | Period register |
| cmp_val | input | NCH*WIDTH | Compare value per channel, channel n at bits [n*WIDTH +: WIDTH] |
| out_mode | input | NCH*3 | Output mode per channel, channel n at bits [n*3 +: 3] |
| out_bit | input | NCH | Direct output value used in output mode 0 |
| count | output | WIDTH | Counter value |
| ch_out | output | NCH | Channel outputs |
| wrap_pulse | output | 1 | One-cycle flag on each return to zero |

## Verification
The bench builds the block with WIDTH=16, NCH=2 and the up/down variant enabled. With these values, one full continuous-mode rollover fits inside the run, and the fourth counter mode takes its own path. With two channels, the collision case (compare 0) and the one-tick case (compare 1) run side by side in the same periods. The same pairing is used for the 2-tick and 1-tick set/reset examples and for the 50 % and 100 % duty points.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

   typedef enum logic [1:0] {
      CM_STOP = 2'd0,
      CM_UP   = 2'd1,
      CM_CONT = 2'd2,
      CM_UPDN = 2'd3
   } cnt_mode_e;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_SET    = 2'd1,
      ACT_CLEAR  = 2'd2,
      ACT_TOGGLE = 2'd3
   } out_act_e;

   localparam int OM_W = 3;

   function automatic out_act_e cmp_action(input logic [OM_W-1:0] om);
      case (om)
         3'd1, 3'd3:       cmp_action = ACT_SET;
         3'd2, 3'd4, 3'd6: cmp_action = ACT_TOGGLE;
         3'd5, 3'd7:       cmp_action = ACT_CLEAR;
         default:          cmp_action = ACT_NONE;
      endcase
   endfunction

   function automatic out_act_e per_action(input logic [OM_W-1:0] om);
      case (om)
         3'd2, 3'd3: per_action = ACT_CLEAR;
         3'd6, 3'd7: per_action = ACT_SET;
         default:    per_action = ACT_NONE;
      endcase
   endfunction

   function automatic logic apply_act(input out_act_e a, input logic cur);
      case (a)
         ACT_SET:    apply_act = 1'b1;
         ACT_CLEAR:  apply_act = 1'b0;
         ACT_TOGGLE: apply_act = ~cur;
         default:    apply_act = cur;
      endcase
   endfunction

endpackage

// File: rtl/tcmp_counter.sv
module tcmp_counter
   import tcmp_pkg::*;
#(
   parameter int WIDTH     = 16,
   parameter bit UPDOWN_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic [1:0]       cnt_mode,
   input  logic [WIDTH-1:0] period_val,
   output logic [WIDTH-1:0] count,
   output logic [WIDTH-1:0] cnt_next,
   output logic             run_tick,
   output logic             per_hit,
   output logic             wrap_pulse
);

   localparam logic [WIDTH-1:0] ZERO = '0;
   localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

   initial begin
      assert (WIDTH >= 2 && WIDTH <= 32)
         else $error("tcmp_counter: WIDTH out of range");
   end

   logic mode_up, mode_cont, mode_ud;
   logic [WIDTH-1:0] up_next, cont_next, ud_next;
   logic ud_dir, ud_dir_next;

   assign mode_up   = (cnt_mode == CM_UP);
   assign mode_cont = (cnt_mode == CM_CONT);
   assign mode_ud   = (cnt_mode == CM_UPDN) && UPDOWN_EN;
   assign run_tick  = tick_en && (mode_up || mode_cont || mode_ud);

   assign up_next   = (count >= period_val) ? ZERO : count + ONE;
   assign cont_next = count + ONE;

   generate
      if (UPDOWN_EN) begin : g_updown
         always_comb begin
            ud_dir_next = ud_dir;
            if (ud_dir) begin
               if (count >= period_val) begin
                  ud_dir_next = 1'b0;
                  ud_next     = (count == ZERO) ? ZERO : count - ONE;
               end else begin
                  ud_next = count + ONE;
               end
            end else begin
               if (count == ZERO) begin
                  ud_dir_next = 1'b1;
                  ud_next     = (period_val == ZERO) ? ZERO : ONE;
               end else begin
                  ud_next = count - ONE;
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ud_dir <= 1'b1;
            else if (run_tick && mode_ud)
               ud_dir <= ud_dir_next;
         end
      end else begin : g_no_updown
         assign ud_next     = count;
         assign ud_dir      = 1'b1;
         assign ud_dir_next = 1'b1;
      end
   endgenerate

   always_comb begin
      cnt_next = count;
      if (run_tick) begin
         if (mode_up)
            cnt_next = up_next;
         else if (mode_cont)
            cnt_next = cont_next;
         else
            cnt_next = ud_next;
      end
   end

   // period event: zero after wrap in up mode, period equality otherwise
   assign per_hit = run_tick &&
                    (mode_up ? (cnt_next == ZERO) : (cnt_next == period_val));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count      <= ZERO;
         wrap_pulse <= 1'b0;
      end else begin
         count      <= cnt_next;
         wrap_pulse <= run_tick && (cnt_next == ZERO);
      end
   end

   AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && cnt_mode == CM_UP && count < period_val) |=> count == $past(count) + ONE); // R1

   AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && cnt_mode == CM_UP && count >= period_val) |=> count == ZERO); // R1

   AST_CONT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && cnt_mode == CM_CONT) |=> count == $past(count) + ONE); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en || cnt_mode == CM_STOP) |=> $stable(count)); // R3

   AST_FLAG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_pulse |-> count == ZERO); // R5

endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel
   import tcmp_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_tick,
   input  logic             per_hit,
   input  logic [WIDTH-1:0] cnt_next,
   input  logic [WIDTH-1:0] cmp_val,
   input  logic [OM_W-1:0]  out_mode,
   input  logic             out_bit,
   output logic             ch_out
);

   logic cmp_hit;
   logic out_next;

   assign cmp_hit = run_tick && (cnt_next == cmp_val);

   always_comb begin
      out_next = ch_out;
      if (out_mode == 3'd0)
         out_next = out_bit;
      else if (cmp_hit)
         out_next = apply_act(cmp_action(out_mode), ch_out);
      else if (per_hit)
         out_next = apply_act(per_action(out_mode), ch_out);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ch_out <= 1'b0;
      else
         ch_out <= out_next;
   end

   AST_DIRECT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_mode == 3'd0) |=> ch_out == $past(out_bit)); // R6

   AST_CMP_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_hit && (out_mode == 3'd5 || out_mode == 3'd7)) |=> !ch_out); // R10

   AST_CMP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_hit && (out_mode == 3'd1 || out_mode == 3'd3)) |=> ch_out); // R7

   AST_NO_EVENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_tick && out_mode != 3'd0) |=> $stable(ch_out)); // R3

endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
   import tcmp_pkg::*;
#(
   parameter int WIDTH     = 16,
   parameter int NCH       = 2,
   parameter bit UPDOWN_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick_en,
   input  logic [1:0]            cnt_mode,
   input  logic [WIDTH-1:0]      period_val,
   input  logic [NCH*WIDTH-1:0]  cmp_val,
   input  logic [NCH*OM_W-1:0]   out_mode,
   input  logic [NCH-1:0]        out_bit,
   output logic [WIDTH-1:0]      count,
   output logic [NCH-1:0]        ch_out,
   output logic                  wrap_pulse
);

   initial begin
      assert (NCH >= 1 && NCH <= 16)
         else $error("tcmp_unit: NCH out of range");
   end

   logic [WIDTH-1:0] cnt_next;
   logic             run_tick;
   logic             per_hit;

   tcmp_counter #(
      .WIDTH     (WIDTH),
      .UPDOWN_EN (UPDOWN_EN)
   ) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .cnt_mode   (cnt_mode),
      .period_val (period_val),
      .count      (count),
      .cnt_next   (cnt_next),
      .run_tick   (run_tick),
      .per_hit    (per_hit),
      .wrap_pulse (wrap_pulse)
   );

   generate
      for (genvar n = 0; n < NCH; n++) begin : g_ch
         tcmp_channel #(
            .WIDTH (WIDTH)
         ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_tick (run_tick),
            .per_hit  (per_hit),
            .cnt_next (cnt_next),
            .cmp_val  (cmp_val[n*WIDTH +: WIDTH]),
            .out_mode (out_mode[n*OM_W +: OM_W]),
            .out_bit  (out_bit[n]),
            .ch_out   (ch_out[n])
         );
      end
   endgenerate

endmodule

// File: tb/tcmp_unit_tb.sv
module tcmp_unit_tb_top;

   localparam int W    = 16;
   localparam int NCH  = 2;
   localparam int MODN = 1 << W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              tick_en = 1'b0;
   logic [1:0]        cnt_mode = 2'd0;
   logic [W-1:0]      period_val = '0;
   logic [NCH*W-1:0]  cmp_val = '0;
   logic [NCH*3-1:0]  out_mode = '0;
   logic [NCH-1:0]    out_bit = '0;
   logic [W-1:0]      count;
   logic [NCH-1:0]    ch_out;
   logic              wrap_pulse;

   int checks = 0;
   int errors = 0;
   bit cmp_on = 1'b0;

   always #2.5 clk = ~clk;

   tcmp_unit #(.WIDTH(W), .NCH(NCH), .UPDOWN_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_mode(cnt_mode),
      .period_val(period_val), .cmp_val(cmp_val), .out_mode(out_mode),
      .out_bit(out_bit), .count(count), .ch_out(ch_out), .wrap_pulse(wrap_pulse)
   );

   // behavioural reference, advanced on each rising edge
   int  m_cnt = 0;
   bit  m_up = 1'b1;
   bit  m_flag = 1'b0;
   bit  m_out [NCH];
   int  nc, pv, cv, om;
   bit  run, ev_c, ev_p;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_up = 1'b1; m_flag = 1'b0;
         for (int k = 0; k < NCH; k++) m_out[k] = 1'b0;
      end else begin
         pv  = int'(period_val);
         run = tick_en && (cnt_mode != 2'd0);
         nc  = m_cnt;
         if (run) begin
            if (cnt_mode == 2'd1) nc = (m_cnt >= pv) ? 0 : m_cnt + 1;
            else if (cnt_mode == 2'd2) nc = (m_cnt + 1) % MODN;
            else if (m_up) begin
               if (m_cnt >= pv) begin m_up = 1'b0; nc = (m_cnt == 0) ? 0 : m_cnt - 1; end
               else nc = m_cnt + 1;
            end else begin
               if (m_cnt == 0) begin m_up = 1'b1; nc = (pv == 0) ? 0 : 1; end
               else nc = m_cnt - 1;
            end
         end
         for (int k = 0; k < NCH; k++) begin
            om = int'(out_mode[k*3 +: 3]);
            cv = int'(cmp_val[k*W +: W]);
            ev_c = run && (nc == cv);
            ev_p = run && ((cnt_mode == 2'd1) ? (nc == 0) : (nc == pv));
            if (om == 0) m_out[k] = out_bit[k];
            else if (ev_c) begin
               if (om == 1 || om == 3) m_out[k] = 1'b1;
               else if (om == 5 || om == 7) m_out[k] = 1'b0;
               else m_out[k] = ~m_out[k];
            end else if (ev_p) begin
               if (om == 2 || om == 3) m_out[k] = 1'b0;
               else if (om == 6 || om == 7) m_out[k] = 1'b1;
            end
         end
         m_flag = run && (nc == 0);
         m_cnt  = nc;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R1 count", int'(count), m_cnt);
         chk("R5 wrap_pulse", int'(wrap_pulse), int'(m_flag));
         for (int k = 0; k < NCH; k++)
            chk("R7 ch_out", int'(ch_out[k]), int'(m_out[k]));
      end
   end

   task automatic set_ch(input int k, input int mode, input int cmp);
      out_mode[k*3 +: 3] = mode[2:0];
      cmp_val[k*W +: W]  = cmp[W-1:0];
   endtask

   task automatic measure(input int n, output int hi0, output int hi1, output int wraps);
      hi0 = 0; hi1 = 0; wraps = 0;
      repeat (n) begin
         @(negedge clk);
         hi0 += int'(ch_out[0]);
         hi1 += int'(ch_out[1]);
         wraps += int'(wrap_pulse);
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      int h0, h1, wr, held;
      repeat (3) @(negedge clk);
      chk("R1 reset count", int'(count), 0);
      chk("R1 reset outputs", int'(ch_out), 0);
      chk("R1 reset flag", int'(wrap_pulse), 0);
      rst_n = 1'b1;
      cmp_on = 1'b1;

      // R8: set/reset in up mode, 2-tick and 1-tick cases
      period_val = 16'h18; cnt_mode = 2'd1; tick_en = 1'b1;
      set_ch(0, 3, 16'h17); set_ch(1, 3, 16'h18);
      repeat (60) @(negedge clk);
      measure(100, h0, h1, wr);
      chk("R8 mode3 cmp 0x17 high ticks", h0, 8);
      chk("R8 mode3 cmp=period high ticks", h1, 4);
      chk("R1 period is period+1 ticks", wr, 4);

      // R10: mode 7 with compare 0 and compare 1
      set_ch(0, 7, 0); set_ch(1, 7, 1);
      repeat (60) @(negedge clk);
      measure(50, h0, h1, wr);
      chk("R10 mode7 cmp 0 stays low", h0, 0);
      chk("R10 mode7 cmp 1 one tick per period", h1, 2);

      // R11: duty sweep end points
      period_val = 16'd99; set_ch(0, 7, 100); set_ch(1, 7, 50);
      repeat (220) @(negedge clk);
      measure(100, h0, h1, wr);
      chk("R11 cmp 100 full duty", h0, 100);
      chk("R11 cmp 50 half duty", h1, 50);

      // R12: output change on the edge where count takes the compare value
      period_val = 16'd30; set_ch(0, 1, 0); set_ch(1, 5, 0);
      repeat (40) @(negedge clk);
      set_ch(0, 5, 12); set_ch(1, 1, 12);
      while (count != 16'd11) @(negedge clk);
      chk("R12 before compare ch0", int'(ch_out[0]), 1);
      @(negedge clk);
      chk("R12 count at compare", int'(count), 12);
      chk("R12 ch0 cleared on that edge", int'(ch_out[0]), 0);
      chk("R12 ch1 set on that edge", int'(ch_out[1]), 1);

      // R7: remaining codes in up mode with gated ticks
      set_ch(0, 2, 7); set_ch(1, 6, 20);
      for (int i = 0; i < 120; i++) begin @(negedge clk); tick_en = (i % 3) != 1; end
      set_ch(0, 4, 5); set_ch(1, 1, 9);
      for (int i = 0; i < 120; i++) begin @(negedge clk); tick_en = (i % 5) != 0; end
      tick_en = 1'b1;

      // R3: stop mode and disabled ticks
      set_ch(0, 4, 3); set_ch(1, 6, 4);
      repeat (7) @(negedge clk);
      cnt_mode = 2'd0; @(negedge clk); held = int'(count);
      repeat (10) @(negedge clk);
      chk("R3 stop holds count", int'(count), held);
      cnt_mode = 2'd1; tick_en = 1'b0; @(negedge clk); held = int'({count, ch_out});
      repeat (10) @(negedge clk);
      chk("R3 tick_en low holds state", int'({count, ch_out}), held);
      tick_en = 1'b1;

      // R6: direct output bit
      set_ch(0, 0, 0); set_ch(1, 0, 0);
      out_bit = 2'b01; @(negedge clk);
      chk("R6 direct bits 01", int'(ch_out), 1);
      out_bit = 2'b10; @(negedge clk);
      chk("R6 direct bits 10", int'(ch_out), 2);
      tick_en = 1'b0; out_bit = 2'b11; @(negedge clk);
      chk("R6 direct bits with ticks off", int'(ch_out), 3);
      tick_en = 1'b1;

      // R4 / R9: up/down mode
      period_val = 16'd10; cnt_mode = 2'd3; set_ch(0, 4, 3); set_ch(1, 3, 7);
      repeat (45) @(negedge clk);
      measure(40, h0, h1, wr);
      chk("R4 up/down wraps per 40 ticks", wr, 2);
      chk("R9 up/down set/reset high ticks", h1, 34);

      // R2 / R9: continuous mode over one full rollover
      set_ch(0, 0, 0); out_bit = 2'b00; @(negedge clk);
      cnt_mode = 2'd2; period_val = 16'h0100; set_ch(0, 3, 16'h00F0); set_ch(1, 6, 16'h0200);
      measure(MODN + 300, h0, h1, wr);
      chk("R2 continuous rollover count", wr, 1);
      measure(MODN, h0, h1, wr);
      chk("R9 continuous set/reset high ticks", h0, 16);
      chk("R2 one wrap per 2^W ticks", wr, 1);

      cmp_on = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule